// File: doc/BRIEF.md
# Sound-Processor Bank Window Address Mapper

This block sits on the 16-bit address bus of an 8-bit sound processor and sends every access to one of three targets. The first is a four-location port that talks to a sound synthesis chip. The second is a 9-bit bank register that is loaded one bit per write. The third is a 32 KiB window into a 24-bit system bus. The window covers the upper half of the processor's address space. The bank register supplies the upper address bits of every window access, so the processor can reach any 32 KiB slice of system memory.

An accepted access that is not for the window completes on the following cycle with a one-cycle done pulse. A window access instead raises a request toward the system bus. The request carries the full system address, the write flag, the data and a one-hot byte-lane mask. The processor wait output stays high until the system bus acknowledges. The block then returns the read byte together with the done pulse.

For the sound chip, the block produces two strobes (register-address write and data write), a part-select bit and the byte to write. A data write always goes to the part chosen by the most recent register-address write.

Top module: `bank_window_mapper`

## Requirements
- R1: After synchronous reset, `sys_req`, `cpu_wait`, `cpu_done`, `fm_addr_we` and `fm_data_we` are low, and the bank register holds zero. The first window access after reset therefore carries system address bits 23..15 equal to zero.
- R2: An accepted write to exactly 0x6000 shifts the bank register right by one place and loads bit 0 of the write data into bank bit 8. The write completes on the next cycle.
- R3: An accepted access whose address bit 15 is 1 raises `sys_req` on the next cycle. It presents `sys_addr` = {bank, address bits 14..0}, `sys_we` equal to the processor write flag, and for writes `sys_wdata` equal to the processor data.
- R4: Window accesses are single bytes. `sys_lane` is 2'b10 when address bit 0 is 0 and 2'b01 when it is 1, so exactly one bit is set.
- R5: `sys_req` and `cpu_wait` stay high, and the request fields stay stable, until a cycle in which `sys_ack` is high. On the next cycle `sys_req` and `cpu_wait` are low and `cpu_done` is high, and for reads `cpu_rdata` equals the `sys_rdata` value sampled in the acknowledge cycle.
- R6: An accepted write to 0x4000 or 0x4002 pulses `fm_addr_we` on the next cycle. `fm_wdata` carries the written byte, and `fm_part` is address bit 1 (0 for 0x4000, 1 for 0x4002).
- R7: An accepted write to 0x4001 or 0x4003 pulses `fm_data_we` on the next cycle with the written byte. `fm_part` equals the part of the most recent register-address write; the part latch resets to 0.
- R8: An accepted read of any address from 0x4000 through 0x4003 completes on the next cycle. `cpu_rdata` equals the `fm_status` value from the acceptance cycle.
- R9: Any address below 0x8000 that is neither 0x4000–0x4003 nor a write to 0x6000 is undecoded. This includes reads of 0x6000. Such a read returns 0xFF. Such a write completes without any sound-chip strobe, without a system request and without changing the bank register.
- R10: A request presented while `cpu_wait` is high is not accepted. It has no effect on the bank register, the sound-chip outputs or the system request.
- R11: A non-window access never raises `sys_req` or `cpu_wait`, and it pulses `cpu_done` exactly one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request; accepted when `cpu_wait` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data, valid while `cpu_done` is high |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_wait | output | 1 | High while a window access is outstanding |
| fm_status | input | 8 | Sound chip status byte |
| fm_addr_we | output | 1 | Sound chip register-address write strobe |
| fm_data_we | output | 1 | Sound chip data write strobe |
| fm_part | output | 1 | Sound chip register part select |
| fm_wdata | output | 8 | Byte for the sound chip |
| sys_req | output | 1 | System bus request |
| sys_we | output | 1 | System bus write flag |
| sys_addr | output | 24 | System bus byte address |
| sys_lane | output | 2 | Byte lane mask: bit 1 even byte, bit 0 odd byte |
| sys_wdata | output | 8 | System bus write byte |
| sys_ack | input | 1 | System bus acknowledge |
| sys_rdata | input | 8 | System bus read byte |

## Verification
Two events can fall in the same cycle. A bank-register shift lands on the same clock edge at which the next window access is accepted. The bench provokes this by issuing a bank write and then a window read on the very next cycle, without waiting for the first done pulse, and it expects the window address to carry the already-shifted bank. The bench also holds `sys_ack` high before the request rises, so the acknowledge coincides with the first cycle of `sys_req`; the done pulse and returned byte must then appear one cycle later. A bank write presented while a window access is pending must leave the bank unchanged, and the bench judges this from the address of a later window read.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int WIN_BITS = CPU_AW - 1;

    localparam logic [CPU_AW-1:0] FM_BASE   = 16'h4000;
    localparam logic [CPU_AW-1:0] BANK_ADDR = 16'h6000;
    localparam logic [DATA_W-1:0] OPEN_BUS  = 8'hFF;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_FM   = 2'd1,
        RG_BANK = 2'd2,
        RG_WIN  = 2'd3
    } region_e;

    typedef struct packed {
        logic              we;
        logic [CPU_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } cpu_acc_t;

    typedef struct packed {
        logic              addr_we;
        logic              data_we;
        logic              part;
        logic [DATA_W-1:0] data;
    } fm_cmd_t;

    function automatic region_e classify(input logic [CPU_AW-1:0] a, input logic we);
        if (a[CPU_AW-1])
            return RG_WIN;
        else if (a[CPU_AW-1:2] == FM_BASE[CPU_AW-1:2])
            return RG_FM;
        else if (a == BANK_ADDR && we)
            return RG_BANK;
        else
            return RG_NONE;
    endfunction

endpackage

// File: rtl/bwm_bank_reg.sv
module bwm_bank_reg #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BANK_W-1:0] bank_q
);
    logic [BANK_W-1:0] bank_d;

    // right shift; new bit enters at the top
    generate
        for (genvar i = 0; i < BANK_W - 1; i++) begin : g_shift
            assign bank_d[i] = bank_q[i+1];
        end
    endgenerate
    assign bank_d[BANK_W-1] = bit_in;

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (shift_en)
            bank_q <= bank_d;
    end
endmodule

// File: rtl/bwm_fm_port.sv
module bwm_fm_port
    import bwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [1:0]        acc_sel,
    input  logic [DATA_W-1:0] acc_data,
    output fm_cmd_t           cmd_q
);
    logic part_q;
    logic is_data;

    assign is_data = acc_sel[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            part_q <= 1'b0;
        end else begin
            cmd_q.addr_we <= acc_en && acc_we && !is_data;
            cmd_q.data_we <= acc_en && acc_we && is_data;
            if (acc_en && acc_we) begin
                cmd_q.data <= acc_data;
                cmd_q.part <= is_data ? part_q : acc_sel[1];
                if (!is_data)
                    part_q <= acc_sel[1];
            end
        end
    end
endmodule

// File: rtl/bwm_window_ctrl.sv
module bwm_window_ctrl #(
    parameter int SYS_W  = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_we,
    input  logic [SYS_W-1:0]  start_addr,
    input  logic [1:0]        start_lane,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              sys_ack,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic              sys_req,
    output logic              sys_we,
    output logic [SYS_W-1:0]  sys_addr,
    output logic [1:0]        sys_lane,
    output logic [DATA_W-1:0] sys_wdata,
    output logic              fin,
    output logic [DATA_W-1:0] fin_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sys_req   <= 1'b0;
            sys_we    <= 1'b0;
            sys_addr  <= '0;
            sys_lane  <= '0;
            sys_wdata <= '0;
            fin       <= 1'b0;
            fin_rdata <= '0;
        end else begin
            fin <= 1'b0;
            if (sys_req) begin
                if (sys_ack) begin
                    sys_req   <= 1'b0;
                    fin       <= 1'b1;
                    fin_rdata <= sys_rdata;
                end
            end else if (start) begin
                sys_req   <= 1'b1;
                sys_we    <= start_we;
                sys_addr  <= start_addr;
                sys_lane  <= start_lane;
                sys_wdata <= start_wdata;
            end
        end
    end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper
    import bwm_pkg::*;
#(
    parameter int BANK_W = 9,
    localparam int SYS_W = BANK_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_done,
    output logic              cpu_wait,
    input  logic [7:0]        fm_status,
    output logic              fm_addr_we,
    output logic              fm_data_we,
    output logic              fm_part,
    output logic [7:0]        fm_wdata,
    output logic              sys_req,
    output logic              sys_we,
    output logic [SYS_W-1:0]  sys_addr,
    output logic [1:0]        sys_lane,
    output logic [7:0]        sys_wdata,
    input  logic              sys_ack,
    input  logic [7:0]        sys_rdata
);
    cpu_acc_t          acc;
    region_e           rg;
    logic              accept;
    logic [BANK_W-1:0] bank_q;
    fm_cmd_t           fm_cmd;
    logic              win_fin;
    logic [7:0]        win_rdata;
    logic              loc_done_q;
    logic [7:0]        loc_rdata_q;

    assign acc    = '{we: cpu_we, addr: cpu_addr, data: cpu_wdata};
    assign accept = cpu_req && !cpu_wait;
    assign rg     = classify(acc.addr, acc.we);

    bwm_bank_reg #(.BANK_W(BANK_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept && rg == RG_BANK),
        .bit_in   (acc.data[0]),
        .bank_q   (bank_q)
    );

    bwm_fm_port fm_i (
        .clk      (clk),
        .rst      (rst),
        .acc_en   (accept && rg == RG_FM),
        .acc_we   (acc.we),
        .acc_sel  (acc.addr[1:0]),
        .acc_data (acc.data),
        .cmd_q    (fm_cmd)
    );

    bwm_window_ctrl #(.SYS_W(SYS_W), .DATA_W(DATA_W)) win_i (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && rg == RG_WIN),
        .start_we    (acc.we),
        .start_addr  ({bank_q, acc.addr[WIN_BITS-1:0]}),
        .start_lane  ({~acc.addr[0], acc.addr[0]}),
        .start_wdata (acc.data),
        .sys_ack     (sys_ack),
        .sys_rdata   (sys_rdata),
        .sys_req     (sys_req),
        .sys_we      (sys_we),
        .sys_addr    (sys_addr),
        .sys_lane    (sys_lane),
        .sys_wdata   (sys_wdata),
        .fin         (win_fin),
        .fin_rdata   (win_rdata)
    );

    // local (non-window) completion path
    always_ff @(posedge clk) begin
        if (rst) begin
            loc_done_q  <= 1'b0;
            loc_rdata_q <= '0;
        end else begin
            loc_done_q <= accept && rg != RG_WIN;
            if (accept && rg != RG_WIN)
                loc_rdata_q <= (rg == RG_FM && !acc.we) ? fm_status : OPEN_BUS;
        end
    end

    assign cpu_wait   = sys_req;
    assign cpu_done   = loc_done_q | win_fin;
    assign cpu_rdata  = win_fin ? win_rdata : loc_rdata_q;
    assign fm_addr_we = fm_cmd.addr_we;
    assign fm_data_we = fm_cmd.data_we;
    assign fm_part    = fm_cmd.part;
    assign fm_wdata   = fm_cmd.data;
endmodule

// File: rtl/bank_window_mapper_chk.sv
module bank_window_mapper_chk #(
    parameter int BANK_W = 9,
    localparam int SYS_W = BANK_W + 15
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [15:0]       cpu_addr,
    input logic              wdata_b0,
    input logic              cpu_done,
    input logic              cpu_wait,
    input logic              fm_addr_we,
    input logic              fm_data_we,
    input logic              sys_req,
    input logic [SYS_W-1:0]  sys_addr,
    input logic [1:0]        sys_lane,
    input logic              sys_ack,
    input logic [BANK_W-1:0] bank_q
);
    logic accept;
    logic undecoded_wr;

    assign accept       = cpu_req && !cpu_wait;
    assign undecoded_wr = accept && cpu_we && !cpu_addr[15]
                          && cpu_addr[15:2] != 14'h1000 && cpu_addr != 16'h6000;

    p_bank_shift_r2: assert property (@(posedge clk) disable iff (rst)
        accept && cpu_we && cpu_addr == 16'h6000
        |=> bank_q == {$past(wdata_b0), $past(bank_q[BANK_W-1:1])});

    p_window_addr_r3: assert property (@(posedge clk) disable iff (rst)
        accept && cpu_addr[15]
        |=> sys_req && sys_addr[14:0] == $past(cpu_addr[14:0]));

    p_lane_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        sys_req |-> $countones(sys_lane) == 1);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        sys_req && !sys_ack |=> sys_req && $stable(sys_addr) && cpu_wait);

    p_ack_finish_r5: assert property (@(posedge clk) disable iff (rst)
        sys_req && sys_ack |=> !sys_req && !cpu_wait && cpu_done);

    p_fm_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fm_addr_we, fm_data_we, sys_req && cpu_done}));

    p_open_write_r9: assert property (@(posedge clk) disable iff (rst)
        undecoded_wr |=> $stable(bank_q) && !fm_addr_we && !fm_data_we && !sys_req);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_req && cpu_wait |=> $stable(bank_q));

    p_local_done_r11: assert property (@(posedge clk) disable iff (rst)
        accept && !cpu_addr[15] |=> cpu_done && !sys_req);
endmodule

bind bank_window_mapper bank_window_mapper_chk #(.BANK_W(BANK_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .wdata_b0   (cpu_wdata[0]),
    .cpu_done   (cpu_done),
    .cpu_wait   (cpu_wait),
    .fm_addr_we (fm_addr_we),
    .fm_data_we (fm_data_we),
    .sys_req    (sys_req),
    .sys_addr   (sys_addr),
    .sys_lane   (sys_lane),
    .sys_ack    (sys_ack),
    .bank_q     (bank_q)
);

// File: tb/bank_window_mapper_tb_top.sv
module bank_window_mapper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W     = 9;
    localparam int SYS_W      = BANK_W + 15;
    localparam int KIND_FM    = 0;
    localparam int KIND_SYS   = 1;
    localparam int KIND_DONE  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic cpu_done, cpu_wait;
    logic [7:0] fm_status = 8'h00;
    logic fm_addr_we, fm_data_we, fm_part;
    logic [7:0] fm_wdata;
    logic sys_req, sys_we;
    logic [SYS_W-1:0] sys_addr;
    logic [1:0] sys_lane;
    logic [7:0] sys_wdata;
    logic sys_ack = 1'b0;
    logic [7:0] sys_rdata;

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [7:0]  d;
        logic [1:0]  f;
        logic        chk;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, done_cnt = 0, cycles = 0;
    logic [BANK_W-1:0] bank_m = '0;
    logic part_m = 1'b0;
    int ack_delay = 1, ack_cnt = 0;
    bit ack_hold = 1'b0, finished = 1'b0, req_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_window_mapper #(.BANK_W(BANK_W)) dut_i (.*);

    function automatic logic [7:0] resp(input logic [SYS_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    assign sys_rdata = resp(sys_addr);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] a, input logic [7:0] d,
                        input logic [1:0] f, input logic chk, input string tag);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.f = f; e.chk = chk; e.tag = tag;
        q.push_back(e);
    endtask

    // expected items for one access, from the requirements
    task automatic expect_acc(input logic we, input logic [15:0] addr,
                              input logic [7:0] wd, input string tag);
        logic [SYS_W-1:0] sa;
        if (addr[15]) begin
            sa = {bank_m, addr[14:0]};
            push(KIND_SYS, 32'(sa), wd, {~addr[0], addr[0]}, we, tag);
            push(KIND_DONE, 0, resp(sa), 2'b00, !we, tag);
        end else if (addr[15:2] == 14'h1000) begin
            if (we) begin
                if (!addr[0]) part_m = addr[1];
                push(KIND_FM, {30'd0, addr[0], part_m}, wd, 2'b00, 1'b1, tag);
            end
            push(KIND_DONE, 0, fm_status, 2'b00, !we, tag);
        end else if (addr == 16'h6000 && we) begin
            bank_m = {wd[0], bank_m[BANK_W-1:1]};
            push(KIND_DONE, 0, 8'h00, 2'b00, 1'b0, tag);
        end else begin
            push(KIND_DONE, 0, 8'hFF, 2'b00, !we, tag);
        end
    endtask

    task automatic wait_dones(input int target);
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic access(input logic we, input logic [15:0] addr,
                          input logic [7:0] wd, input string tag);
        int n;
        @(negedge clk);
        while (cpu_wait) @(negedge clk);
        n = done_cnt;
        expect_acc(we, addr, wd, tag);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        wait_dones(n + 1);
    endtask

    // system bus responder
    always @(negedge clk) begin
        if (ack_hold) begin
            sys_ack <= 1'b1;
        end else if (sys_ack) begin
            sys_ack <= 1'b0;
            ack_cnt <= 0;
        end else if (sys_req) begin
            if (ack_cnt >= ack_delay) sys_ack <= 1'b1;
            else ack_cnt <= ack_cnt + 1;
        end
    end

    // monitor / scoreboard
    task automatic pop_cmp(input int kind);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R11", "unexpected event kind", 32'(kind), 32'hFFFF);
            return;
        end
        e = q.pop_front();
        check(e.kind == kind, e.tag, "event kind", 32'(kind), 32'(e.kind));
        if (e.kind != kind) return;
        case (kind)
            KIND_FM: begin
                check({fm_data_we, fm_part} == e.a[1:0], e.tag, "fm strobe/part",
                      {30'd0, fm_data_we, fm_part}, e.a);
                check(fm_wdata == e.d, e.tag, "fm data", fm_wdata, e.d);
            end
            KIND_SYS: begin
                check(sys_addr == e.a[SYS_W-1:0], e.tag, "sys addr", 32'(sys_addr), e.a);
                check(sys_lane == e.f, "R4", "lane", sys_lane, e.f);
                check(sys_we == e.chk, e.tag, "sys we", sys_we, e.chk);
                if (e.chk) check(sys_wdata == e.d, e.tag, "sys wdata", sys_wdata, e.d);
            end
            default: begin
                check(!cpu_wait, e.tag, "wait low at done", cpu_wait, 0);
                if (e.chk) check(cpu_rdata == e.d, e.tag, "rdata", cpu_rdata, e.d);
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (fm_addr_we || fm_data_we) pop_cmp(KIND_FM);
            if (sys_req && !req_prev) pop_cmp(KIND_SYS);
            if (cpu_done) begin
                pop_cmp(KIND_DONE);
                done_cnt++;
            end
            req_prev = sys_req;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!sys_req && !cpu_wait && !cpu_done, "R1", "bus idle after reset",
              {29'd0, sys_req, cpu_wait, cpu_done}, 0);
        check(!fm_addr_we && !fm_data_we, "R1", "fm strobes after reset",
              {30'd0, fm_addr_we, fm_data_we}, 0);

        // R1/R3: bank zero, even-lane read
        ack_delay = 2;
        access(1'b0, 16'h8000, 8'h00, "R1");
        // R2: load 0x1A5 serially (nine writes)
        for (int i = 0; i < 9; i++)
            access(1'b1, 16'h6000, {7'h3F, 1'((9'h1A5 >> i) & 1)}, "R2");
        access(1'b0, 16'h8123, 8'h00, "R3");   // R4 odd lane
        access(1'b1, 16'hFFFE, 8'hC3, "R3");   // R4 even lane write
        ack_delay = 0;
        access(1'b0, 16'hABCD, 8'h00, "R5");

        // R2 back-to-back: bank shift then window access on the next cycle
        @(negedge clk);
        n = done_cnt;
        expect_acc(1'b1, 16'h6000, 8'h00, "R2");
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h6000; cpu_wdata = 8'h00;
        @(negedge clk);
        expect_acc(1'b0, 16'h8421, 8'h00, "R2");
        cpu_we = 1'b0; cpu_addr = 16'h8421;
        @(negedge clk);
        cpu_req = 1'b0;
        wait_dones(n + 2);

        // R5 acknowledge already high when request rises
        ack_hold = 1'b1;
        access(1'b0, 16'h9001, 8'h00, "R5");
        ack_hold = 1'b0;
        @(negedge clk);

        // R6 / R7 sound chip port
        access(1'b1, 16'h4000, 8'h28, "R6");
        access(1'b1, 16'h4001, 8'hF0, "R7");
        access(1'b1, 16'h4002, 8'h30, "R6");
        access(1'b1, 16'h4001, 8'h11, "R7");
        access(1'b1, 16'h4003, 8'h22, "R7");
        access(1'b1, 16'h4000, 8'h44, "R6");
        access(1'b1, 16'h4003, 8'h55, "R7");

        // R8 status reads
        fm_status = 8'h80; access(1'b0, 16'h4000, 8'h00, "R8");
        fm_status = 8'h03; access(1'b0, 16'h4001, 8'h00, "R8");
        fm_status = 8'h7E; access(1'b0, 16'h4002, 8'h00, "R8");
        fm_status = 8'h01; access(1'b0, 16'h4003, 8'h00, "R8");

        // R9 undecoded
        access(1'b0, 16'h1234, 8'h00, "R9");
        access(1'b0, 16'h6000, 8'h00, "R9");
        access(1'b1, 16'h5000, 8'h01, "R9");
        access(1'b1, 16'h6001, 8'h01, "R9");
        access(1'b1, 16'h4004, 8'h01, "R9");
        access(1'b0, 16'h8002, 8'h00, "R9");

        // R10 request while waiting is ignored
        ack_delay = 6;
        @(negedge clk);
        n = done_cnt;
        expect_acc(1'b0, 16'h8004, 8'h00, "R10");
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h8004;
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = 16'h6000; cpu_wdata = 8'h01;
        repeat (3) @(negedge clk);
        cpu_req = 1'b0;
        wait_dones(n + 1);
        ack_delay = 1;
        access(1'b0, 16'h8004, 8'h00, "R10");

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R11", "all expected events seen", q.size(), 0);
        finish_run();
    end
endmodule